// File: doc/BRIEF.md
# I2C Slave with Shared Byte Buffer

This block is an I2C target device that exposes a small on-chip byte buffer to an external bus controller. The controller addresses the slave with a configurable 7-bit device address. A write transaction first names an offset in the buffer and then streams bytes into it. A read transaction streams bytes out of it. Every byte is acknowledged automatically by hardware, and SCL is never held low, so the bus always runs at the controller's pace.

On the chip side, a second port reads and writes the same buffer at any time and needs no arbitration. A one-cycle notification tells local logic that the controller has deposited new data. SCL and SDA are oversampled by the system clock through a short synchronizer. The slave pulls SDA low through an open-drain enable output and never drives it high.

Top module: `i2cbuf_slave`

## Requirements
- R1: The slave acknowledges (drives SDA low during the ninth SCL pulse) an address byte only when its upper seven bits equal `dev_addr_i`. After a mismatched address it leaves SDA released until the next Start.
- R2: In a write transaction (address byte bit 0 = 0), the first byte after the address is an offset. It is acknowledged when below DEPTH, and it becomes both the transfer position and the read start offset.
- R3: Every later byte of a write transaction is stored at the transfer position and acknowledged, and the position then advances by one. The stored bytes are visible on the local port.
- R4: An offset byte of DEPTH or more is not acknowledged. Every further byte of that transaction is not acknowledged and is not stored, and the read start offset keeps its earlier value.
- R5: A data byte that arrives once the transfer position has reached DEPTH is not acknowledged and is not stored. Nothing wraps to offset 0.
- R6: A read transaction (address byte bit 0 = 1) sends bytes MSB first, beginning at the most recently accepted offset, and advances by one after each byte.
- R7: A read at a position of DEPTH or more returns 0xFF.
- R8: A Repeated Start or a Stop restarts the byte sequence, so the next write transaction again begins with an offset byte.
- R9: When the controller does not acknowledge a read byte, the slave releases SDA and keeps it released until the next Start. After a Stop, SDA is released.
- R10: `wr_done_o` is high for exactly one cycle shortly after a Stop, and only when at least one data byte was stored since the previous Stop. Read-only and offset-only transactions produce no pulse.
- R11: The local port writes `cpu_wdata_i` at `cpu_addr_i` when `cpu_we_i` is high. `cpu_rdata_o` returns the byte at `cpu_addr_i` one cycle later and is 0 after reset.
- R12: The slave changes its SDA drive only while SCL is low, and it has no SCL output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_drive_o | output | 1 | 1 pulls SDA low (open drain) |
| dev_addr_i | input | 7 | Configured 7-bit device address |
| cpu_we_i | input | 1 | Local write enable |
| cpu_addr_i | input | $clog2(DEPTH) | Local byte address |
| cpu_wdata_i | input | 8 | Local write data |
| cpu_rdata_o | output | 8 | Local read data, one cycle latency |
| wr_done_o | output | 1 | One-cycle pulse after a Stop that ends a storing write |

## Verification
A wrong bit counter or a wrong state shows up as an acknowledge in the wrong place. That error appears on the controller's next ninth clock, within one byte time of the fault. A wrong transfer position or read start offset does not show at once. It surfaces only on the next data byte, either as an unexpected NACK at the buffer end or as wrong read data, or later, when the local port reads back a byte at the wrong location. Stale storing state shows as a missing or spurious `wr_done_o` pulse a few cycles after the next Stop.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;

    // Bus events derived from the synchronized SCL/SDA levels
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_MACK
    } eng_state_t;

    localparam logic [7:0] EMPTY_BYTE = 8'hFF;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    // Compares the 7-bit part of a received address byte with the device address
    function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] dev);
        return rx[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2cbuf_sync.sv
module i2cbuf_sync
    import i2cbuf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe    <= '1;
                prev[g] <= 1'b1;
            end else begin
                pipe    <= {pipe[STAGES-2:0], raw[g]};
                prev[g] <= pipe[STAGES-1];
            end
        end
        assign cur[g] = pipe[STAGES-1];
    end

    always_comb begin
        ev.scl_rise = cur[0] && !prev[0];
        ev.scl_fall = !cur[0] && prev[0];
        ev.start    = cur[0] && prev[0] && prev[1] && !cur[1];
        ev.stop     = cur[0] && prev[0] && !prev[1] && cur[1];
        ev.sda      = cur[1];
    end

endmodule

// File: rtl/i2cbuf_ram.sv
module i2cbuf_ram #(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    // Both ports write independently; on a same-address collision port A lands last
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) b_rdata <= '0;
        else     b_rdata <= mem[b_addr];
    end

    assign a_rdata = mem[a_addr];

endmodule

// File: rtl/i2cbuf_engine.sv
module i2cbuf_engine
    import i2cbuf_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [6:0]    dev_addr,
    output logic          sda_drive,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    input  logic [7:0]    ram_rdata,
    output logic          wr_done
);
    eng_state_t    state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic          rw;
    logic          first;
    logic          reject;
    logic          wrote;
    logic          mnack;
    logic [PW-1:0] base_ptr;
    logic [PW-1:0] cur_ptr;

    logic       in_range;
    logic       data_ok;
    logic       byte_end;
    logic [7:0] rd_byte;

    assign in_range  = cur_ptr < PW'(DEPTH);
    assign data_ok   = !first && !reject && in_range;
    assign byte_end  = ev.scl_fall && (bitcnt == BITS_PER_BYTE);
    assign rd_byte   = in_range ? ram_rdata : EMPTY_BYTE;
    assign ram_addr  = cur_ptr[AW-1:0];
    assign ram_wdata = shreg;
    assign ram_we    = (state == ST_WDATA) && byte_end && data_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            rw        <= 1'b0;
            first     <= 1'b1;
            reject    <= 1'b0;
            wrote     <= 1'b0;
            mnack     <= 1'b0;
            base_ptr  <= '0;
            cur_ptr   <= '0;
            sda_drive <= 1'b0;
            wr_done   <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            if (ev.stop) begin
                state     <= ST_IDLE;
                sda_drive <= 1'b0;
                wr_done   <= wrote;
                wrote     <= 1'b0;
            end else if (ev.start) begin
                state     <= ST_ADDR;
                bitcnt    <= '0;
                sda_drive <= 1'b0;
                first     <= 1'b1;
                reject    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (ev.scl_rise && bitcnt < BITS_PER_BYTE) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (byte_end) begin
                            bitcnt <= '0;
                            state  <= ST_ACK;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, dev_addr)) begin
                                    sda_drive <= 1'b1;
                                    rw        <= shreg[0];
                                    if (shreg[0]) cur_ptr <= base_ptr;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (first) begin
                                first <= 1'b0;
                                if (int'(shreg) < DEPTH) begin
                                    sda_drive <= 1'b1;
                                    base_ptr  <= PW'(shreg);
                                    cur_ptr   <= PW'(shreg);
                                end else begin
                                    reject <= 1'b1;
                                end
                            end else if (data_ok) begin
                                sda_drive <= 1'b1;
                                cur_ptr   <= cur_ptr + 1'b1;
                                wrote     <= 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            if (rw) begin
                                state     <= ST_RDATA;
                                shreg     <= rd_byte;
                                sda_drive <= ~rd_byte[7];
                            end else begin
                                state     <= ST_WDATA;
                                sda_drive <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_rise && bitcnt < BITS_PER_BYTE) bitcnt <= bitcnt + 4'd1;
                        if (ev.scl_fall) begin
                            if (bitcnt == BITS_PER_BYTE) begin
                                sda_drive <= 1'b0;
                                state     <= ST_MACK;
                                bitcnt    <= '0;
                                if (in_range) cur_ptr <= cur_ptr + 1'b1;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_drive <= ~shreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) mnack <= ev.sda;
                        if (ev.scl_fall) begin
                            if (!mnack) begin
                                state     <= ST_RDATA;
                                shreg     <= rd_byte;
                                sda_drive <= ~rd_byte[7];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cbuf_slave.sv
module i2cbuf_slave
    import i2cbuf_pkg::*;
#(
    parameter  int DEPTH       = 32,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_drive_o,
    input  logic [6:0]    dev_addr_i,
    input  logic          cpu_we_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [7:0]    cpu_wdata_i,
    output logic [7:0]    cpu_rdata_o,
    output logic          wr_done_o
);
    bus_ev_t       bus_ev;
    logic          i2c_we;
    logic [AW-1:0] i2c_addr;
    logic [7:0]    i2c_wdata;
    logic [7:0]    i2c_rdata;

    i2cbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .ev     (bus_ev)
    );

    i2cbuf_engine #(.DEPTH(DEPTH)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev        (bus_ev),
        .dev_addr  (dev_addr_i),
        .sda_drive (sda_drive_o),
        .ram_we    (i2c_we),
        .ram_addr  (i2c_addr),
        .ram_wdata (i2c_wdata),
        .ram_rdata (i2c_rdata),
        .wr_done   (wr_done_o)
    );

    i2cbuf_ram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .a_we    (i2c_we),
        .a_addr  (i2c_addr),
        .a_wdata (i2c_wdata),
        .a_rdata (i2c_rdata),
        .b_we    (cpu_we_i),
        .b_addr  (cpu_addr_i),
        .b_wdata (cpu_wdata_i),
        .b_rdata (cpu_rdata_o)
    );

endmodule

// File: rtl/i2cbuf_checker.sv
module i2cbuf_checker
    import i2cbuf_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    scl_i,
    input bus_ev_t bus_ev,
    input logic    sda_drive_o,
    input logic    wr_done_o,
    input logic    i2c_we
);
    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_drive_o)); // R12

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        bus_ev.stop |=> !sda_drive_o); // R9

    AST_WRDONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_done_o |=> !wr_done_o); // R10

    AST_WRDONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        wr_done_o |-> $past(bus_ev.stop)); // R10

    AST_STORE_ACKED: assert property (@(posedge clk) disable iff (rst)
        i2c_we |=> sda_drive_o); // R3

endmodule

bind i2cbuf_slave i2cbuf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .bus_ev      (bus_ev),
    .sda_drive_o (sda_drive_o),
    .wr_done_o   (wr_done_o),
    .i2c_we      (i2c_we)
);

// File: tb/sim_i2cbuf_slave.sv
module sim_i2cbuf_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int DEPTH      = 32;
    localparam logic [6:0] DEV = 7'h52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       bus_sda;
    logic       sda_drive;
    logic       cpu_we = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       wr_done;

    assign bus_sda = m_sda & ~sda_drive;

    i2cbuf_slave u0 (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (bus_sda),
        .sda_drive_o (sda_drive),
        .dev_addr_i  (DEV),
        .cpu_we_i    (cpu_we),
        .cpu_addr_i  (cpu_addr),
        .cpu_wdata_i (cpu_wdata),
        .cpu_rdata_o (cpu_rdata),
        .wr_done_o   (wr_done)
    );

    typedef struct { int req; logic [7:0] val; } item_t;
    item_t      exp_q[$];
    logic [7:0] act_q[$];
    int total = 0;
    int bad   = 0;

    // bench model of the buffer and the transfer positions
    logic [7:0] mem [DEPTH];
    int m_base = 0;
    int m_cur  = 0;
    bit m_first = 1'b1;
    bit m_reject = 1'b0;
    int wd_count = 0;
    int quiet_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_drv = 1'b0;

    // scoreboard monitor
    always @(negedge clk) begin
        item_t e;
        logic [7:0] a;
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            e = exp_q.pop_front();
            a = act_q.pop_front();
            total++;
            if (a !== e.val) begin
                bad++;
                $display("FAIL R%0d actual=%h expected=%h", e.req, a, e.val);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && wr_done) wd_count++;
        if (!rst && m_scl && prev_scl && sda_drive !== prev_drv) quiet_viol++; // R12
        prev_scl = m_scl;
        prev_drv = sda_drive;
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
        m_first = 1'b1;
        m_reject = 1'b0;
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic shift_out(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = bus_sda; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic shift_in(logic ackbit, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], bus_sda}; tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_sda = ackbit; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0;
        m_sda = 1'b1;
    endtask

    // address byte; R1 expected ack from address equality
    task automatic send_addr(logic [6:0] a, logic rw);
        logic ack;
        item_t e;
        e.req = 1; e.val = {7'b0, (a == DEV) ? 1'b0 : 1'b1};
        exp_q.push_back(e);
        shift_out({a, rw}, ack);
        act_q.push_back({7'b0, ack});
        if (rw && a == DEV) m_cur = m_base;
    endtask

    task automatic send_raw(logic [7:0] b, logic exp_ack, int req);
        logic ack;
        item_t e;
        e.req = req; e.val = {7'b0, exp_ack};
        exp_q.push_back(e);
        shift_out(b, ack);
        act_q.push_back({7'b0, ack});
    endtask

    // write-side byte: offset rules R2/R4, storage rules R3/R5
    task automatic wbyte(logic [7:0] b);
        logic ack;
        item_t e;
        if (m_first) begin
            m_first = 1'b0;
            if (int'(b) < DEPTH) begin e.req = 2; e.val = 8'h00; m_base = int'(b); m_cur = int'(b); end
            else begin e.req = 4; e.val = 8'h01; m_reject = 1'b1; end
        end else if (m_reject) begin
            e.req = 4; e.val = 8'h01;
        end else if (m_cur >= DEPTH) begin
            e.req = 5; e.val = 8'h01;
        end else begin
            e.req = 3; e.val = 8'h00; mem[m_cur] = b; m_cur++;
        end
        exp_q.push_back(e);
        shift_out(b, ack);
        act_q.push_back({7'b0, ack});
    endtask

    // read-side byte: R6 data from position, R7 0xFF past end
    task automatic rbyte(logic last);
        logic [7:0] b;
        item_t e;
        if (m_cur < DEPTH) begin e.req = 6; e.val = mem[m_cur]; m_cur++; end
        else begin e.req = 7; e.val = 8'hFF; end
        exp_q.push_back(e);
        shift_in(last, b);
        act_q.push_back(b);
    endtask

    task automatic cpu_write(int a, logic [7:0] d);
        cpu_addr = 5'(a); cpu_wdata = d; cpu_we = 1'b1;
        tick(1);
        cpu_we = 1'b0;
        mem[a] = d;
    endtask

    task automatic cpu_read(int a, output logic [7:0] d);
        cpu_addr = 5'(a);
        tick(1);
        d = cpu_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int wd_exp;
        int drv_seen;
        wd_exp = 0;
        tick(5);
        rst = 1'b0;
        tick(2);
        // reset state: R9 released SDA, R10 no pulse, R11 read data zero
        check("R9", sda_drive, 0);
        check("R10", wr_done, 0);
        check("R11", cpu_rdata, 0);

        for (int i = 0; i < DEPTH; i++) cpu_write(i, 8'((i * 37 + 5) & 255));
        cpu_read(7, d);  check("R11", d, mem[7]);
        cpu_read(31, d); check("R11", d, mem[31]);

        // R1: foreign address is not acknowledged, nor the following byte
        m_start();
        send_addr(DEV ^ 7'h01, 1'b0);
        send_raw(8'h03, 1'b1, 1);
        m_stop();
        tick(5);
        check("R10", wd_count, wd_exp);
        cpu_read(3, d); check("R1", d, mem[3]);

        // R2, R3: offset then three data bytes
        m_start();
        send_addr(DEV, 1'b0);
        wbyte(8'd4);
        wbyte(8'hA5);
        wbyte(8'h3C);
        wbyte(8'h81);
        m_stop();
        tick(5);
        wd_exp++;
        check("R10", wd_count, wd_exp);
        cpu_read(4, d); check("R3", d, 8'hA5);
        cpu_read(5, d); check("R3", d, 8'h3C);
        cpu_read(6, d); check("R3", d, 8'h81);

        // R6: read restarts at the accepted offset, MSB first
        m_start();
        send_addr(DEV, 1'b1);
        rbyte(1'b0);
        rbyte(1'b0);
        rbyte(1'b1);
        m_stop();

        // R8, R7: offset-only write, repeated start, read over the end
        m_start();
        send_addr(DEV, 1'b0);
        wbyte(8'd30);
        m_start();
        send_addr(DEV, 1'b1);
        rbyte(1'b0);
        rbyte(1'b0);
        rbyte(1'b0);
        rbyte(1'b1);
        m_stop();
        tick(5);
        check("R10", wd_count, wd_exp);

        // R4: out-of-range offset and a following byte are refused
        m_start();
        send_addr(DEV, 1'b0);
        wbyte(8'd40);
        wbyte(8'h77);
        m_stop();
        tick(5);
        check("R4", wd_count, wd_exp);
        m_start();
        send_addr(DEV, 1'b1);
        rbyte(1'b1);
        m_stop();

        // R5: last location stored, next byte refused, no wrap to offset 0
        m_start();
        send_addr(DEV, 1'b0);
        wbyte(8'd31);
        wbyte(8'h55);
        wbyte(8'h66);
        m_stop();
        tick(5);
        wd_exp++;
        check("R10", wd_count, wd_exp);
        cpu_read(31, d); check("R5", d, 8'h55);
        cpu_read(0, d);  check("R5", d, mem[0]);

        // R8: repeated start inside a write makes the next byte an offset again
        m_start();
        send_addr(DEV, 1'b0);
        wbyte(8'd2);
        wbyte(8'h11);
        m_start();
        send_addr(DEV, 1'b0);
        wbyte(8'd8);
        wbyte(8'h22);
        m_stop();
        tick(5);
        wd_exp++;
        check("R10", wd_count, wd_exp);
        cpu_read(2, d); check("R8", d, 8'h11);
        cpu_read(3, d); check("R8", d, mem[3]);
        cpu_read(8, d); check("R8", d, 8'h22);

        // R9: after a controller NACK the slave stays off the bus
        m_start();
        send_addr(DEV, 1'b1);
        rbyte(1'b1);
        drv_seen = 0;
        for (int i = 0; i < 9; i++) begin
            tick(Q); m_scl = 1'b1;
            tick(Q); if (sda_drive) drv_seen++;
            tick(Q); m_scl = 1'b0;
            tick(Q); if (sda_drive) drv_seen++;
        end
        check("R9", drv_seen, 0);
        m_stop();
        tick(5);
        check("R10", wd_count, wd_exp);

        check("R12", quiet_viol, 0);
        tick(5);
        check("R6", exp_q.size() + act_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule